// File: doc/BRIEF.md
# Display Interface Control and Status Register

This block holds the fourteen control and status flags of a point-plotting display interface that sits on a 36-bit host I/O bus. It watches the device field of every bus command. When that field carries its own device number, it accepts a two-phase condition-out write: a clear strobe, then a set strobe that can only raise flags. It also accepts a condition-in read, during which it places the flags on the bus, and a data-out clear that marks the interface not ready. Events from the display side raise or drop the busy, ready and light-pen flags without any device selection.

The flags are also given to the neighbouring point-load sequencer and coordinate buffers. Two 3-bit channel codes are decoded into one-hot priority interrupt request vectors. The light-pen request is gated by the light-pen flag, and the ready request is gated by the ready flag. A read clears the light-pen flag once the read strobe has ended.

Bus numbering follows the host convention: bit 0 is the most significant bit of the 36-bit word. Host bit n is vector index 35-n on `cmd_word`, `io_data_in` and `io_data_out`.

Top module: `dpy_csr`

## Requirements
- R1: The device is selected only when command bits 3..9 (vector [32:26], bit 3 most significant) equal octal 134. `cond_clr`, `cond_set`, `stat_rd` and `data_clr` have no effect while the device is not selected.
- R2: `bus_rst`, which needs no selection, and a selected `cond_clr` both zero all fourteen flags at the next rising edge. `rst_n` low also zeroes them.
- R3: The flags in `csr_q`, from most to least significant bit, are: [13] busy, [12] light-pen, [11] ready, [10] Y-only, [9] X-only, [8:6] intensity, [5:3] light-pen channel, [2:0] ready channel. A selected `cond_set` ORs host bits 24..35 (`io_data_in[11:0]`) into `csr_q[11:0]`.
- R4: A selected `cond_set` never raises busy or light-pen, even when every data bit is 1.
- R5: While `stat_rd` is high and the device is selected, `io_data_out` carries the flags on host bits 22..35 (`io_data_out[13:0]` = `csr_q`) and all other bits are 0. At all other times `io_data_out` is all zero.
- R6: `pt_load` sets busy, and `pt_done` clears it.
- R7: `pen_hit` sets the light-pen flag. A selected read clears the flag at the first rising edge at which `stat_rd` is sampled low after being sampled high. The flag stays set while the read is in progress.
- R8: `pt_load` sets the ready flag, and a selected `data_clr` clears it.
- R9: For a channel code c, request line c-1 of the vector is high exactly when c is not 0 and the gating flag is set (light-pen for `pi_lp_req`, ready for `pi_rdy_req`). Code 0 drives no line, and at most one line is ever high.
- R10: When a set event and a clear event reach the same flag in the same cycle, the flag ends up at 1.
- R11: `int_level` ranks the two's complement intensity code from 0 to 7: code 100 gives 0 (dimmest) and code 011 gives 7 (brightest).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous chip reset, active low |
| cmd_word | input | 36 | Host I/O command word; device field in host bits 3..9 |
| io_data_in | input | 36 | Host data lines, used by a condition-out set |
| cond_clr | input | 1 | Condition-out clear strobe |
| cond_set | input | 1 | Condition-out set strobe |
| stat_rd | input | 1 | Condition-in read level, several cycles long |
| data_clr | input | 1 | Data-out clear strobe |
| bus_rst | input | 1 | Host bus reset strobe, needs no selection |
| pt_load | input | 1 | Point-load pulse toward the display |
| pt_done | input | 1 | Point-done pulse from the display |
| pen_hit | input | 1 | Light-pen hit pulse from the display |
| io_data_out | output | 36 | Status word driven during a selected read |
| csr_q | output | 14 | The fourteen flags |
| int_level | output | 3 | Intensity rank, 0 dimmest to 7 brightest |
| pi_lp_req | output | 7 | One-hot light-pen interrupt request lines for channels 1..7 |
| pi_rdy_req | output | 7 | One-hot ready interrupt request lines for channels 1..7 |

## Verification
The bench builds the block with its default parameters: a 36-bit word, device number octal 134 in host bits 3..9, status on host bits 22..35 and 3-bit channel codes. With these values the full field layout can be observed. The channel sweep covers all eight codes for each vector, including code 0. The device-field tests use a neighbouring number that differs from 134 in one bit, which shows that a near miss is ignored. The light-pen read-clear is checked against the exact edge after the read ends, and also in the same cycle as a new pen hit.

// File: rtl/dpy_csr_pkg.sv
package dpy_csr_pkg;
  localparam int FLAG_W    = 14;
  localparam int SET_W     = 12;
  localparam int CH_W      = 3;
  localparam int CH_LINES  = (1 << CH_W) - 1;
  localparam int F_BUSY    = 13;
  localparam int F_PEN     = 12;
  localparam int F_RDY     = 11;
  localparam int F_YONLY   = 10;
  localparam int F_XONLY   = 9;
  localparam int F_INT_LO  = 6;
  localparam int F_PCH_LO  = 3;
  localparam int F_RCH_LO  = 0;

  // Map two's complement intensity code to an unsigned brightness rank.
  function automatic logic [CH_W-1:0] bright_rank(input logic [CH_W-1:0] code);
    return {~code[CH_W-1], code[CH_W-2:0]};
  endfunction

  // Index of a host bit (bit 0 = MSB) inside a vector of width w.
  function automatic int host_idx(input int w, input int host_bit);
    return w - 1 - host_bit;
  endfunction
endpackage

// File: rtl/dpy_addr_dec.sv
module dpy_addr_dec #(
  parameter int CMD_W = 36,
  parameter int DEV_FIRST = 3,
  parameter int DEV_W = 7,
  parameter logic [DEV_W-1:0] DEV_NUM = 7'o134
) (
  input  logic [CMD_W-1:0] cmd_word,
  output logic             sel
);
  localparam int IDX_HI = CMD_W - 1 - DEV_FIRST;
  localparam int IDX_LO = IDX_HI - DEV_W + 1;

  logic unused_cmd;
  assign unused_cmd = ^cmd_word;
  assign sel = (cmd_word[IDX_HI:IDX_LO] == DEV_NUM);
endmodule

// File: rtl/dpy_rd_edge.sv
module dpy_rd_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_lvl,
  output logic rd_active,
  output logic rd_fall
);
  logic rd_q;
  assign rd_active = rd_lvl;
  assign rd_fall   = rd_q & ~rd_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= 1'b0;
    else        rd_q <= rd_lvl;
  end
endmodule

// File: rtl/dpy_flag_reg.sv
module dpy_flag_reg
  import dpy_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_all,
  input  logic             clr_pen,
  input  logic             clr_rdy,
  input  logic             clr_busy,
  input  logic             set_busy,
  input  logic             set_pen,
  input  logic             set_rdy,
  input  logic             host_set,
  input  logic [SET_W-1:0] host_bits,
  output logic [FLAG_W-1:0] q
);
  logic [FLAG_W-1:0] clr_mask;
  logic [FLAG_W-1:0] set_mask;

  always_comb begin
    clr_mask = {FLAG_W{clr_all}};
    clr_mask[F_PEN]  = clr_mask[F_PEN]  | clr_pen;
    clr_mask[F_RDY]  = clr_mask[F_RDY]  | clr_rdy;
    clr_mask[F_BUSY] = clr_mask[F_BUSY] | clr_busy;
  end

  genvar i;
  generate
    for (i = 0; i < FLAG_W; i++) begin : g_set
      if (i < SET_W) begin : g_host
        logic side;
        if (i == F_RDY) begin : g_r
          assign side = set_rdy;
        end else begin : g_n
          assign side = 1'b0;
        end
        assign set_mask[i] = (host_set & host_bits[i]) | side;
      end else if (i == F_BUSY) begin : g_busy
        assign set_mask[i] = set_busy;
      end else begin : g_pen
        assign set_mask[i] = set_pen;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= (q & ~clr_mask) | set_mask;
  end
endmodule

// File: rtl/dpy_pi_dec.sv
module dpy_pi_dec #(
  parameter int CH_W = 3,
  localparam int LINES = (1 << CH_W) - 1
) (
  input  logic [CH_W-1:0] code,
  input  logic            en,
  output logic [LINES-1:0] req
);
  genvar c;
  generate
    for (c = 1; c <= LINES; c++) begin : g_line
      assign req[c-1] = en & (code == CH_W'(c));
    end
  endgenerate
endmodule

// File: rtl/dpy_csr.sv
module dpy_csr
  import dpy_csr_pkg::*;
#(
  parameter int CMD_W = 36,
  parameter int DEV_FIRST = 3,
  parameter int DEV_W = 7,
  parameter logic [DEV_W-1:0] DEV_NUM = 7'o134,
  parameter int STAT_FIRST = 22,
  parameter int SET_FIRST = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CMD_W-1:0]     cmd_word,
  input  logic [CMD_W-1:0]     io_data_in,
  input  logic                 cond_clr,
  input  logic                 cond_set,
  input  logic                 stat_rd,
  input  logic                 data_clr,
  input  logic                 bus_rst,
  input  logic                 pt_load,
  input  logic                 pt_done,
  input  logic                 pen_hit,
  output logic [CMD_W-1:0]     io_data_out,
  output logic [FLAG_W-1:0]    csr_q,
  output logic [CH_W-1:0]      int_level,
  output logic [CH_LINES-1:0]  pi_lp_req,
  output logic [CH_LINES-1:0]  pi_rdy_req
);
  localparam int STAT_OFS = CMD_W - STAT_FIRST - FLAG_W;
  localparam int SET_OFS  = CMD_W - SET_FIRST - SET_W;

  // Named internal events, visible to the bound checker.
  logic sel;
  logic rd_active;
  logic rd_fall;
  logic clr_all;
  logic host_set;
  logic unused_data;

  assign unused_data = ^io_data_in;

  dpy_addr_dec #(.CMD_W(CMD_W), .DEV_FIRST(DEV_FIRST), .DEV_W(DEV_W), .DEV_NUM(DEV_NUM))
    u_dec (.cmd_word(cmd_word), .sel(sel));

  dpy_rd_edge u_rd (.clk(clk), .rst_n(rst_n), .rd_lvl(stat_rd & sel),
                    .rd_active(rd_active), .rd_fall(rd_fall));

  assign clr_all  = bus_rst | (cond_clr & sel);
  assign host_set = cond_set & sel;

  dpy_flag_reg u_flags (
    .clk(clk), .rst_n(rst_n),
    .clr_all(clr_all), .clr_pen(rd_fall), .clr_rdy(data_clr & sel), .clr_busy(pt_done),
    .set_busy(pt_load), .set_pen(pen_hit), .set_rdy(pt_load),
    .host_set(host_set), .host_bits(io_data_in[SET_OFS +: SET_W]),
    .q(csr_q));

  always_comb begin
    io_data_out = '0;
    if (rd_active) io_data_out[STAT_OFS +: FLAG_W] = csr_q;
  end

  assign int_level = bright_rank(csr_q[F_INT_LO +: CH_W]);

  dpy_pi_dec #(.CH_W(CH_W)) u_pi_pen (.code(csr_q[F_PCH_LO +: CH_W]), .en(csr_q[F_PEN]), .req(pi_lp_req));
  dpy_pi_dec #(.CH_W(CH_W)) u_pi_rdy (.code(csr_q[F_RCH_LO +: CH_W]), .en(csr_q[F_RDY]), .req(pi_rdy_req));
endmodule

// File: rtl/dpy_csr_chk.sv
module dpy_csr_chk
  import dpy_csr_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                sel,
  input logic                rd_fall,
  input logic                clr_all,
  input logic                cond_set,
  input logic                stat_rd,
  input logic                bus_rst,
  input logic                pt_load,
  input logic                pt_done,
  input logic                pen_hit,
  input logic [35:0]         io_data_out,
  input logic [FLAG_W-1:0]   csr_q,
  input logic [CH_LINES-1:0] pi_lp_req,
  input logic [CH_LINES-1:0] pi_rdy_req
);
  p_unsel_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel && !bus_rst && !pt_load && !pt_done && !pen_hit && !rd_fall) |=> $stable(csr_q));

  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_all && !pt_load && !pen_hit && !(cond_set && sel)) |=> (csr_q == '0));

  p_no_host_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pt_load && !csr_q[F_BUSY]) |=> !csr_q[F_BUSY]);

  p_bus_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(stat_rd && sel) |-> (io_data_out == '0));

  p_busy_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pt_done && !pt_load) |=> !csr_q[F_BUSY]);

  p_load_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pt_load |=> (csr_q[F_BUSY] && csr_q[F_RDY]));

  p_pen_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fall && !pen_hit) |=> !csr_q[F_PEN]);

  p_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pi_lp_req) && $onehot0(pi_rdy_req));

  p_pen_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_q[F_PEN] |-> (pi_lp_req == '0));

  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pen_hit |=> csr_q[F_PEN]);
endmodule

bind dpy_csr dpy_csr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .rd_fall(rd_fall), .clr_all(clr_all),
  .cond_set(cond_set), .stat_rd(stat_rd), .bus_rst(bus_rst), .pt_load(pt_load),
  .pt_done(pt_done), .pen_hit(pen_hit), .io_data_out(io_data_out), .csr_q(csr_q),
  .pi_lp_req(pi_lp_req), .pi_rdy_req(pi_rdy_req));

// File: tb/dpy_csr_test.sv
`timescale 1ns/1ps
module dpy_csr_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [35:0] cmd_word = '0, io_data_in = '0;
  logic cond_clr = 0, cond_set = 0, stat_rd = 0, data_clr = 0, bus_rst = 0;
  logic pt_load = 0, pt_done = 0, pen_hit = 0;
  logic [35:0] io_data_out;
  logic [13:0] csr_q;
  logic [2:0]  int_level;
  logic [6:0]  pi_lp_req, pi_rdy_req;

  int checks = 0, errors = 0;
  string tag = "R2";
  logic [13:0] m = '0;
  bit m_rd = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dpy_csr uut (.*);

  function automatic logic [35:0] dev_cmd(input int dev);
    logic [35:0] w;
    w = '0;
    for (int b = 0; b < 7; b++) w[35 - (3 + b)] = dev[6 - b];
    return w;
  endfunction

  function automatic bit selected();
    int d;
    d = 0;
    for (int b = 3; b <= 9; b++) d = d * 2 + int'(cmd_word[35 - b]);
    return d == 'o134;
  endfunction

  task automatic model_step();
    logic [13:0] clr, st;
    bit s, rd_now;
    s = selected();
    rd_now = stat_rd && s;
    clr = '0; st = '0;
    if (bus_rst || (cond_clr && s)) clr = '1;
    if (m_rd && !rd_now) clr[12] = 1'b1;
    if (data_clr && s) clr[11] = 1'b1;
    if (pt_done) clr[13] = 1'b1;
    if (cond_set && s) for (int n = 24; n <= 35; n++) st[35 - n] = io_data_in[35 - n];
    if (pt_load) begin st[13] = 1'b1; st[11] = 1'b1; end
    if (pen_hit) st[12] = 1'b1;
    m = (m & ~clr) | st;
    m_rd = rd_now;
  endtask

  task automatic check(input string what, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    logic [35:0] bus_exp;
    int pcode, rcode, ic;
    logic [6:0] lp_exp, rd_exp;
    bus_exp = '0;
    if (stat_rd && selected()) for (int n = 22; n <= 35; n++) bus_exp[35 - n] = m[35 - n];
    pcode = int'(m[5:3]); rcode = int'(m[2:0]); ic = int'(m[8:6]);
    lp_exp = (m[12] && pcode != 0) ? 7'(1 << (pcode - 1)) : 7'd0;
    rd_exp = (m[11] && rcode != 0) ? 7'(1 << (rcode - 1)) : 7'd0;
    check("flags", 36'(csr_q), 36'(m));
    check("bus", io_data_out, bus_exp);
    check("pen_pi", 36'(pi_lp_req), 36'(lp_exp));
    check("rdy_pi", 36'(pi_rdy_req), 36'(rd_exp));
    check("level", 36'(int_level), 36'((ic + 4) % 8));
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic drop_strobes();
    cond_clr = 0; cond_set = 0; data_clr = 0; bus_rst = 0;
    pt_load = 0; pt_done = 0; pen_hit = 0;
  endtask

  task automatic host_write(input logic [35:0] cmd, input logic [11:0] bits);
    cmd_word = cmd;
    cond_clr = 1; tick(); drop_strobes();
    tick();
    io_data_in = {24'hFFFFFF, bits};
    cond_set = 1; tick(); drop_strobes();
    io_data_in = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    tag = "R2";
    check("reset flags", 36'(csr_q), 36'd0);
    rst_n = 1'b1;
    tick();

    tag = "R1";
    host_write(dev_cmd('o135), 12'hFFF);
    tick();
    cmd_word = dev_cmd('o135); stat_rd = 1; tick(); tick(); stat_rd = 0; tick();

    tag = "R3";
    host_write(dev_cmd('o134), 12'hA5C);
    tick();
    host_write(dev_cmd('o134), 12'h3F1);

    tag = "R4";
    cmd_word = dev_cmd('o134);
    io_data_in = '1; cond_set = 1; tick(); drop_strobes(); io_data_in = '0; tick();

    tag = "R5";
    stat_rd = 1; tick(); tick(); tick(); stat_rd = 0; tick();

    tag = "R6";
    host_write(dev_cmd('o134), 12'h000);
    pt_load = 1; tick(); drop_strobes(); tick();
    pt_done = 1; tick(); drop_strobes(); tick();

    tag = "R8";
    data_clr = 1; cmd_word = dev_cmd('o130); tick(); drop_strobes();
    cmd_word = dev_cmd('o134); data_clr = 1; tick(); drop_strobes(); tick();

    tag = "R7";
    host_write(dev_cmd('o134), 12'b000_000_101_000);
    pen_hit = 1; tick(); drop_strobes();
    stat_rd = 1; tick(); tick(); tick();
    stat_rd = 0; tick(); tick();

    tag = "R9";
    for (int c = 0; c < 8; c++) begin
      host_write(dev_cmd('o134), 12'(((c & 7) << 3) | (7 - c)));
      pen_hit = 1; pt_load = 1; tick(); drop_strobes(); tick();
    end
    host_write(dev_cmd('o134), 12'b000_000_011_110);
    tick();

    tag = "R10";
    pen_hit = 1; tick(); drop_strobes();
    stat_rd = 1; tick(); tick();
    stat_rd = 0; pen_hit = 1; tick(); drop_strobes(); tick();
    cond_clr = 1; pt_load = 1; tick(); drop_strobes(); tick();
    pt_done = 1; pt_load = 1; tick(); drop_strobes(); tick();

    tag = "R11";
    for (int k = 0; k < 8; k++) begin
      host_write(dev_cmd('o134), 12'(k << 6));
      tick();
    end

    tag = "R2";
    host_write(dev_cmd('o134), 12'hFFF);
    pen_hit = 1; pt_load = 1; tick(); drop_strobes();
    cmd_word = dev_cmd('o027); bus_rst = 1; tick(); drop_strobes(); tick();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule